// File: doc/BRIEF.md
# Oversampling Serial Receiver with Noise and Framing Flags

This block receives asynchronous serial frames on a single line that it samples at sixteen times the bit rate, paced by a one-cycle sample-strobe input from an external rate generator. A falling edge on an idle line starts a frame. The block decides the start bit, each of the eight data bits and the checked stop bit by a two-of-three vote over the three centre samples of the bit. The assembled byte goes into a data register and a receive-ready flag rises.

A noise flag and a framing-error flag are loaded in the same cycle as receive-ready. The byte is delivered whether or not the frame had errors. Software reads a small register file: a status word and the data byte. The two error flags clear only when a status read is followed by a data read. Four stop-bit arrangements are supported: one and two stop bits for normal links, and a half and one-and-a-half stop bits for card links. The one-and-a-half arrangement samples late in the stop period, so that a card that pulls the line low to refuse a byte is caught as a framing error. An error-interrupt output serves multi-transfer operation.

Top module: `os_uart_rx`

## Requirements
- R1: After reset, receive-ready, noise, framing error and the error interrupt are all 0, and the status word reads 0.
- R2: A falling edge on an idle line is taken as a start only if the vote over samples 8, 9 and 10 of the start bit is low. Otherwise the receiver returns to idle with no frame and no flag change, and a later valid frame is received normally.
- R3: Each bit takes the two-of-three majority of samples 8, 9 and 10 of its 16-sample period. Eight data bits arrive least significant bit first. At frame end the byte is placed in the data register (read select 1) and receive-ready sets. A data read clears receive-ready unless a frame completes in that same cycle.
- R4: If the three voted samples of the start bit, of any data bit or of the checked stop bit differ, the frame's noise flag is set, and the majority value is still used as the bit.
- R5: With stop mode 2'b00 (one stop bit), the stop bit is voted on samples 8 to 10. A low majority sets the framing-error flag, and the byte is still delivered. The frame ends on stop sample 16.
- R6: With stop mode 2'b01 (half stop bit), the stop bit is not sampled, so no framing error or stop-bit noise can arise. Receive-ready rises one clock after the strobe of stop sample 8.
- R7: With stop mode 2'b11 (one and a half stop bits), the stop bit is voted on samples 16 to 18 of the stop period. A low level there is a framing error, while a low level only on samples 8 to 10 is not. Receive-ready rises one clock after the strobe of stop sample 24 and not before.
- R8: With stop mode 2'b10 (two stop bits), only the first stop bit is voted, on its samples 8 to 10. A low second stop bit causes no error. The frame ends on stop sample 32.
- R9: Noise and framing flags are loaded from each completed frame in the same cycle that receive-ready is set.
- R10: Status word (read select 0): bit 0 receive-ready, bit 1 noise, bit 2 framing error, other bits 0. Noise and framing flags clear only on a data read preceded by a status read with no frame completing in between. A data read alone, or status reads alone, leave them set.
- R11: The error interrupt is high exactly when multi-transfer mode and error-interrupt enable are both 1 and noise or framing error is set. It stays low in single-transfer mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| os_tick_i | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd_i | input | 1 | Serial line, idle high |
| stop_mode_i | input | 2 | 00 one, 01 half, 10 two, 11 one and a half stop bits |
| multibuf_i | input | 1 | Multi-transfer operation select |
| err_irq_en_i | input | 1 | Error interrupt enable |
| rd_en_i | input | 1 | Register read strobe |
| rd_sel_i | input | 1 | 0 status word, 1 data byte |
| rd_data_o | output | 8 | Read data for the selected register |
| ready_o | output | 1 | Receive-ready flag |
| noise_o | output | 1 | Noise flag |
| frame_err_o | output | 1 | Framing-error flag |
| err_irq_o | output | 1 | Error interrupt |

## Verification
The bench builds the block with its defaults of 16 samples per bit and 8 data bits, and fires the sample strobe on every fourth clock. That spacing lets each line value the bench drives cross the input synchronizer and be seen on exactly one strobe, so every sample position, including 8, 10, 16, 18, 24 and 32 of the stop period, can be hit on purpose. With 16 samples per bit, the one-and-a-half late vote window and the end points of all four stop arrangements land on distinct sample numbers. This lets the bench tell an early-window low from a late-window refusal, and check receive-ready one sample before and at the end of the stop period.

// File: rtl/os_uart_rx_pkg.sv
package os_uart_rx_pkg;

  typedef enum logic [1:0] {
    STOP_ONE      = 2'b00,
    STOP_HALF     = 2'b01,
    STOP_TWO      = 2'b10,
    STOP_ONE_HALF = 2'b11
  } stop_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_DATA   = 1'b1
  } reg_sel_e;

  localparam int STAT_READY = 0;
  localparam int STAT_NOISE = 1;
  localparam int STAT_FRAME = 2;

endpackage

// File: rtl/os_uart_rx_sync.sv
module os_uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rxd_i,
  output logic rx_o,
  output logic rx_prev_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], rxd_i};
    prev_d = prev_q;
    if (tick_i) prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rx_o      = sync_q[STAGES-1];
  assign rx_prev_o = prev_q;

endmodule

// File: rtl/os_uart_rx_vote.sv
module os_uart_rx_vote (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_a_i,
  input  logic cap_b_i,
  input  logic rx_i,
  output logic maj_o,
  output logic noisy_o
);

  logic a_q, a_d, b_q, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (cap_a_i) a_d = rx_i;
    if (cap_b_i) b_d = rx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b1;
      b_q <= 1'b1;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  // third sample is the live line value at the deciding strobe
  assign maj_o   = (a_q & b_q) | (a_q & rx_i) | (b_q & rx_i);
  assign noisy_o = !((a_q == b_q) && (b_q == rx_i));

endmodule

// File: rtl/os_uart_rx_seq.sv
module os_uart_rx_seq
  import os_uart_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          rx_prev_i,
  input  logic [1:0]    stop_mode_i,
  input  logic          vote_maj_i,
  input  logic          vote_noisy_i,
  output logic          cap_a_o,
  output logic          cap_b_o,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          noise_o,
  output logic          frame_err_o
);

  localparam int CNT_W = $clog2(2*OVS + 1);
  localparam int BIT_W = $clog2(DW);
  localparam logic [CNT_W-1:0] P_MID    = CNT_W'(OVS/2);
  localparam logic [CNT_W-1:0] P_LATE   = CNT_W'(OVS);
  localparam logic [CNT_W-1:0] P_BITEND = CNT_W'(OVS);
  localparam logic [CNT_W-1:0] L_HALF   = CNT_W'(OVS/2);
  localparam logic [CNT_W-1:0] L_ONE    = CNT_W'(OVS);
  localparam logic [CNT_W-1:0] L_ONEH   = CNT_W'(OVS + OVS/2);
  localparam logic [CNT_W-1:0] L_TWO    = CNT_W'(2*OVS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW-1);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [DW-1:0]    sh_q, sh_d;
  logic             noise_q, noise_d;
  logic             fe_q, fe_d;
  logic             done_q, done_d;

  stop_mode_e       mode;
  logic [CNT_W-1:0] pos, first, stop_len;
  logic             vote_on, decide;

  // sample bookkeeping
  always_comb begin
    mode    = stop_mode_e'(stop_mode_i);
    pos     = cnt_q + CNT_W'(1);
    vote_on = (state_q == ST_START) || (state_q == ST_DATA) ||
              ((state_q == ST_STOP) && (mode != STOP_HALF));
    first   = ((state_q == ST_STOP) && (mode == STOP_ONE_HALF)) ? P_LATE : P_MID;
    unique case (mode)
      STOP_ONE:      stop_len = L_ONE;
      STOP_HALF:     stop_len = L_HALF;
      STOP_TWO:      stop_len = L_TWO;
      STOP_ONE_HALF: stop_len = L_ONEH;
      default:       stop_len = L_ONE;
    endcase
    cap_a_o = tick_i && vote_on && (pos == first);
    cap_b_o = tick_i && vote_on && (pos == first + CNT_W'(1));
    decide  = tick_i && vote_on && (pos == first + CNT_W'(2));
  end

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    noise_d = noise_q;
    fe_d    = fe_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tick_i && rx_prev_i && !rx_i) begin
          state_d = ST_START;
          cnt_d   = CNT_W'(1);
          noise_d = 1'b0;
          fe_d    = 1'b0;
        end
      end
      ST_START: begin
        if (tick_i) begin
          cnt_d = pos;
          if (decide) begin
            if (vote_maj_i) begin
              state_d = ST_IDLE;
              cnt_d   = '0;
            end else begin
              noise_d = noise_q | vote_noisy_i;
            end
          end else if (pos == P_BITEND) begin
            state_d = ST_DATA;
            cnt_d   = '0;
            bit_d   = '0;
          end
        end
      end
      ST_DATA: begin
        if (tick_i) begin
          cnt_d = pos;
          if (decide) begin
            sh_d    = {vote_maj_i, sh_q[DW-1:1]};
            noise_d = noise_q | vote_noisy_i;
          end
          if (pos == P_BITEND) begin
            cnt_d = '0;
            if (bit_q == LAST_BIT) state_d = ST_STOP;
            else                   bit_d   = bit_q + BIT_W'(1);
          end
        end
      end
      ST_STOP: begin
        if (tick_i) begin
          cnt_d = pos;
          if (decide) begin
            fe_d    = !vote_maj_i;
            noise_d = noise_q | vote_noisy_i;
          end
          if (pos == stop_len) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
            cnt_d   = '0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      noise_q <= 1'b0;
      fe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      noise_q <= noise_d;
      fe_q    <= fe_d;
      done_q  <= done_d;
    end
  end

  assign done_o      = done_q;
  assign data_o      = sh_q;
  assign noise_o     = noise_q;
  assign frame_err_o = fe_q;

endmodule

// File: rtl/os_uart_rx_regs.sv
module os_uart_rx_regs
  import os_uart_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [DW-1:0] fr_data_i,
  input  logic          fr_noise_i,
  input  logic          fr_fe_i,
  input  logic          rd_en_i,
  input  logic          rd_sel_i,
  input  logic          multibuf_i,
  input  logic          err_irq_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          ready_o,
  output logic          noise_o,
  output logic          frame_err_o,
  output logic          err_irq_o
);

  logic [DW-1:0] data_q, data_d;
  logic          ready_q, ready_d;
  logic          noise_q, noise_d;
  logic          fe_q, fe_d;
  logic          armed_q, armed_d;
  logic [DW-1:0] status;
  reg_sel_e      sel;

  always_comb begin
    sel     = reg_sel_e'(rd_sel_i);
    data_d  = data_q;
    ready_d = ready_q;
    noise_d = noise_q;
    fe_d    = fe_q;
    armed_d = armed_q;
    if (done_i) begin
      data_d  = fr_data_i;
      ready_d = 1'b1;
      noise_d = fr_noise_i;
      fe_d    = fr_fe_i;
      armed_d = 1'b0;
    end else if (rd_en_i) begin
      if (sel == SEL_STATUS) begin
        armed_d = 1'b1;
      end else begin
        ready_d = 1'b0;
        armed_d = 1'b0;
        if (armed_q) begin
          noise_d = 1'b0;
          fe_d    = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      noise_q <= 1'b0;
      fe_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      ready_q <= ready_d;
      noise_q <= noise_d;
      fe_q    <= fe_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    status             = '0;
    status[STAT_READY] = ready_q;
    status[STAT_NOISE] = noise_q;
    status[STAT_FRAME] = fe_q;
    rd_data_o          = (sel == SEL_DATA) ? data_q : status;
  end

  assign ready_o     = ready_q;
  assign noise_o     = noise_q;
  assign frame_err_o = fe_q;
  assign err_irq_o   = multibuf_i && err_irq_en_i && (noise_q || fe_q);

endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx #(
  parameter int OVS         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          os_tick_i,
  input  logic          rxd_i,
  input  logic [1:0]    stop_mode_i,
  input  logic          multibuf_i,
  input  logic          err_irq_en_i,
  input  logic          rd_en_i,
  input  logic          rd_sel_i,
  output logic [DW-1:0] rd_data_o,
  output logic          ready_o,
  output logic          noise_o,
  output logic          frame_err_o,
  output logic          err_irq_o
);

  logic [1:0]    rst_q;
  logic          rst_int_n;
  logic          rx_s, rx_prev;
  logic          cap_a, cap_b, maj, noisy;
  logic          frame_done;
  logic [DW-1:0] fr_data;
  logic          fr_noise, fr_fe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  os_uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick_i    (os_tick_i),
    .rxd_i     (rxd_i),
    .rx_o      (rx_s),
    .rx_prev_o (rx_prev)
  );

  os_uart_rx_vote u_vote (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cap_a_i (cap_a),
    .cap_b_i (cap_b),
    .rx_i    (rx_s),
    .maj_o   (maj),
    .noisy_o (noisy)
  );

  os_uart_rx_seq #(.OVS(OVS), .DW(DW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .tick_i       (os_tick_i),
    .rx_i         (rx_s),
    .rx_prev_i    (rx_prev),
    .stop_mode_i  (stop_mode_i),
    .vote_maj_i   (maj),
    .vote_noisy_i (noisy),
    .cap_a_o      (cap_a),
    .cap_b_o      (cap_b),
    .done_o       (frame_done),
    .data_o       (fr_data),
    .noise_o      (fr_noise),
    .frame_err_o  (fr_fe)
  );

  os_uart_rx_regs #(.DW(DW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .done_i       (frame_done),
    .fr_data_i    (fr_data),
    .fr_noise_i   (fr_noise),
    .fr_fe_i      (fr_fe),
    .rd_en_i      (rd_en_i),
    .rd_sel_i     (rd_sel_i),
    .multibuf_i   (multibuf_i),
    .err_irq_en_i (err_irq_en_i),
    .rd_data_o    (rd_data_o),
    .ready_o      (ready_o),
    .noise_o      (noise_o),
    .frame_err_o  (frame_err_o),
    .err_irq_o    (err_irq_o)
  );

endmodule

// File: rtl/os_uart_rx_chk.sv
module os_uart_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] stop_mode_i,
  input logic       multibuf_i,
  input logic       err_irq_en_i,
  input logic       rd_en_i,
  input logic       rd_sel_i,
  input logic       ready_o,
  input logic       noise_o,
  input logic       frame_err_o,
  input logic       err_irq_o,
  input logic       frame_done
);

  logic seen_status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     seen_status_q <= 1'b0;
    else if (frame_done)            seen_status_q <= 1'b0;
    else if (rd_en_i && !rd_sel_i)  seen_status_q <= 1'b1;
    else if (rd_en_i && rd_sel_i)   seen_status_q <= 1'b0;
  end

  assert_flags_with_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(noise_o) || $rose(frame_err_o)) |-> (ready_o && $past(frame_done)));

  assert_half_no_fe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && stop_mode_i == 2'b01) |=> !frame_err_o);

  assert_clear_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(noise_o) || $fell(frame_err_o)) |->
      ($past(rd_en_i && rd_sel_i) || $past(frame_done)));

  assert_clear_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_sel_i && !seen_status_q && !frame_done && frame_err_o) |=> frame_err_o);

  assert_ready_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_sel_i && !frame_done) |=> !ready_o);

  assert_irq_single_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !multibuf_i |-> !err_irq_o);

  assert_irq_raised_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (multibuf_i && err_irq_en_i && frame_err_o) |-> err_irq_o);

endmodule

bind os_uart_rx os_uart_rx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stop_mode_i  (stop_mode_i),
  .multibuf_i   (multibuf_i),
  .err_irq_en_i (err_irq_en_i),
  .rd_en_i      (rd_en_i),
  .rd_sel_i     (rd_sel_i),
  .ready_o      (ready_o),
  .noise_o      (noise_o),
  .frame_err_o  (frame_err_o),
  .err_irq_o    (err_irq_o),
  .frame_done   (frame_done)
);

// File: tb/os_uart_rx_tb.sv
`timescale 1ns/1ps
module os_uart_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] stop_mode = 2'b00;
  logic       mb = 1'b0, eie = 1'b0;
  logic       rd_en = 1'b0, rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       ready, noise, fe, irq;
  logic [1:0] tdiv = 2'd0;
  logic       tick;
  int         checks = 0, errors = 0;
  bit         finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  os_uart_rx u_dut (
    .clk(clk), .rst_n(rst_n), .os_tick_i(tick), .rxd_i(rxd),
    .stop_mode_i(stop_mode), .multibuf_i(mb), .err_irq_en_i(eie),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .ready_o(ready), .noise_o(noise), .frame_err_o(fe), .err_irq_o(irq)
  );

  function automatic logic maj3(input logic [2:0] p);
    return (p[0] & p[1]) | (p[0] & p[2]) | (p[1] & p[2]);
  endfunction

  function automatic logic noisy3(input logic [2:0] p);
    return !(p == 3'b000 || p == 3'b111);
  endfunction

  function automatic int chk_pos(input logic [1:0] m);
    return (m == 2'b11) ? 16 : 8;
  endfunction

  function automatic int stop_len(input logic [1:0] m);
    case (m)
      2'b00: return 16;
      2'b01: return 8;
      2'b10: return 32;
      default: return 24;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive a value that is seen on exactly the next strobe
  task automatic one_sample(input logic v);
    rxd = v;
    do @(negedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic send_bit(input int len, input logic base, input int p, input logic [2:0] pat);
    for (int s = 1; s <= len; s++) begin
      logic v;
      v = base;
      if (s == p)     v = pat[2];
      if (s == p + 1) v = pat[1];
      if (s == p + 2) v = pat[0];
      one_sample(v);
    end
  endtask

  task automatic send_head(input logic [2:0] spat, input logic [7:0][2:0] dpat);
    send_bit(3, 1'b1, 0, 3'b111);
    send_bit(16, 1'b0, 8, spat);
    for (int i = 0; i < 8; i++) send_bit(16, maj3(dpat[i]), 8, dpat[i]);
  endtask

  task automatic send_stop(input logic [1:0] m, input logic [2:0] pat, input int p, input logic low2);
    if (m == 2'b10) begin
      send_bit(16, 1'b1, p, pat);
      send_bit(16, !low2, 0, 3'b111);
    end else begin
      send_bit(stop_len(m), 1'b1, p, pat);
    end
  endtask

  task automatic reg_read(input logic sel, output logic [7:0] val);
    @(negedge clk);
    rd_en = 1'b1;
    rd_sel = sel;
    #1 val = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_frame(input string req, input logic [7:0] ed, input logic en, input logic ef);
    logic [7:0] v;
    reg_read(1'b0, v);
    check(req, "status after frame", {29'd0, v[2:0]}, {29'd0, ef, en, 1'b1});
    check("R11", "error interrupt", {31'd0, irq}, {31'd0, mb & eie & (en | ef)});
    reg_read(1'b1, v);
    check(req, "data byte", {24'd0, v}, {24'd0, ed});
    reg_read(1'b0, v);
    check("R10", "status after clear sequence", {29'd0, v[2:0]}, 32'd0);
  endtask

  task automatic do_frame(input string req, input logic [1:0] m, input logic [2:0] spat,
                          input logic [7:0][2:0] dpat, input logic [2:0] stpat,
                          input int p, input logic low2);
    logic [7:0] ed;
    logic       en, ef, checked;
    stop_mode = m;
    send_head(spat, dpat);
    send_stop(m, stpat, p, low2);
    send_bit(4, 1'b1, 0, 3'b111);
    checked = (m != 2'b01) && (p == chk_pos(m));
    en = noisy3(spat) || (checked && noisy3(stpat));
    for (int i = 0; i < 8; i++) begin
      ed[i] = maj3(dpat[i]);
      en = en || noisy3(dpat[i]);
    end
    ef = checked && !maj3(stpat);
    check_frame(req, ed, en, ef);
  endtask

  function automatic logic [7:0][2:0] clean(input logic [7:0] d);
    logic [7:0][2:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[i] ? 3'b111 : 3'b000;
    return r;
  endfunction

  function automatic logic [2:0] rnd_pat(input logic b);
    logic [2:0] p;
    p = b ? 3'b111 : 3'b000;
    if ($urandom_range(3, 0) == 0) begin
      int k;
      k = $urandom_range(2, 0);
      p[k] = ~p[k];
    end
    return p;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0][2:0] dp;
    logic [7:0]      v;
    void'($urandom(32'h1234_5eed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", "flags after reset", {28'd0, irq, fe, noise, ready}, 32'd0);
    reg_read(1'b0, v);
    check("R1", "status word after reset", {24'd0, v}, 32'd0);

    // R3 clean frame, one stop bit, LSB first
    do_frame("R3", 2'b00, 3'b000, clean(8'hA5), 3'b111, 8, 1'b0);
    do_frame("R3", 2'b00, 3'b000, clean(8'h3C), 3'b111, 8, 1'b0);

    // R4 disagreeing samples: majority kept, noise set
    dp = clean(8'h81);
    dp[0] = 3'b101; dp[7] = 3'b110; dp[3] = 3'b001;
    do_frame("R4", 2'b00, 3'b000, dp, 3'b111, 8, 1'b0);
    do_frame("R4", 2'b00, 3'b001, clean(8'h5A), 3'b111, 8, 1'b0);
    do_frame("R4", 2'b00, 3'b000, clean(8'h11), 3'b101, 8, 1'b0);

    // R5 framing error in one stop mode, byte still delivered
    do_frame("R5", 2'b00, 3'b000, clean(8'hC3), 3'b000, 8, 1'b0);

    // R2 false start: short low glitch, then a good frame
    send_bit(3, 1'b1, 0, 3'b111);
    send_bit(10, 1'b0, 8, 3'b111);
    send_bit(40, 1'b1, 0, 3'b111);
    check("R2", "no frame after glitch", {29'd0, fe, noise, ready}, 32'd0);
    do_frame("R2", 2'b00, 3'b000, clean(8'h69), 3'b111, 8, 1'b0);

    // R6 half stop: low stop not sampled, ready after sample 8
    do_frame("R6", 2'b01, 3'b000, clean(8'hF0), 3'b000, 8, 1'b0);
    stop_mode = 2'b01;
    send_head(3'b000, clean(8'h0F));
    send_bit(8, 1'b1, 0, 3'b111);
    @(negedge clk);
    check("R6", "ready one clock after stop sample 8", {31'd0, ready}, 32'd1);
    send_bit(4, 1'b1, 0, 3'b111);
    check_frame("R6", 8'h0F, 1'b0, 1'b0);

    // R7 one and a half: late low is an error, early low is not
    do_frame("R7", 2'b11, 3'b000, clean(8'h96), 3'b000, 16, 1'b0);
    do_frame("R7", 2'b11, 3'b000, clean(8'h96), 3'b000, 8, 1'b0);
    stop_mode = 2'b11;
    send_head(3'b000, clean(8'h2B));
    send_bit(23, 1'b1, 0, 3'b111);
    @(negedge clk);
    check("R7", "not ready at stop sample 23", {31'd0, ready}, 32'd0);
    one_sample(1'b1);
    @(negedge clk);
    check("R7", "ready one clock after stop sample 24", {31'd0, ready}, 32'd1);
    send_bit(4, 1'b1, 0, 3'b111);
    check_frame("R7", 8'h2B, 1'b0, 1'b0);

    // R8 two stop bits: second stop low ignored, first checked
    do_frame("R8", 2'b10, 3'b000, clean(8'h77), 3'b111, 8, 1'b1);
    do_frame("R8", 2'b10, 3'b000, clean(8'h77), 3'b000, 8, 1'b0);

    // R10 clear sequence
    stop_mode = 2'b00;
    send_head(3'b000, clean(8'h44));
    send_stop(2'b00, 3'b000, 8, 1'b0);
    send_bit(4, 1'b1, 0, 3'b111);
    check("R9", "flags with ready", {29'd0, fe, noise, ready}, 32'b101);
    reg_read(1'b1, v);
    check("R10", "data read alone keeps error", {30'd0, fe, ready}, 32'b10);
    reg_read(1'b0, v);
    reg_read(1'b0, v);
    check("R10", "status reads alone keep error", {31'd0, fe}, 32'd1);
    reg_read(1'b1, v);
    check("R10", "status then data clears error", {31'd0, fe}, 32'd0);
    reg_read(1'b0, v);
    send_head(3'b000, clean(8'h45));
    send_stop(2'b00, 3'b000, 8, 1'b0);
    send_bit(4, 1'b1, 0, 3'b111);
    reg_read(1'b1, v);
    check("R10", "frame between status and data disarms", {31'd0, fe}, 32'd1);
    reg_read(1'b0, v);
    reg_read(1'b1, v);
    check("R10", "cleared after fresh sequence", {30'd0, fe, noise}, 32'd0);

    // R11 error interrupt gating
    mb = 1'b1; eie = 1'b1;
    do_frame("R11", 2'b00, 3'b000, clean(8'h12), 3'b000, 8, 1'b0);
    eie = 1'b0;
    do_frame("R11", 2'b00, 3'b000, clean(8'h34), 3'b000, 8, 1'b0);
    mb = 1'b0; eie = 1'b1;
    do_frame("R11", 2'b00, 3'b001, clean(8'h56), 3'b000, 8, 1'b0);
    eie = 1'b0;

    // random frames over all modes
    for (int n = 0; n < 30; n++) begin
      logic [7:0]      d;
      logic [1:0]      m;
      logic [2:0]      sp;
      logic [7:0][2:0] rp;
      d = 8'($urandom);
      m = 2'($urandom);
      for (int i = 0; i < 8; i++) rp[i] = rnd_pat(d[i]);
      sp = ($urandom_range(4, 0) == 0) ? 3'b000 : rnd_pat(1'b1);
      mb = 1'($urandom); eie = 1'($urandom);
      do_frame("R4", m, rnd_pat(1'b0), rp, sp, chk_pos(m), 1'($urandom));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule